// File: doc/BRIEF.md
# Refresh Counter and Opcode-Fetch Cycle Sequencer

This block sequences the machine cycles that fetch the bytes of each instruction for an 8-bit processor whose opcodes can carry prefix bytes. It decides whether each fetched byte is read with an opcode-fetch (M1) cycle or with an ordinary memory-read cycle, and it counts out the T-states of every machine cycle. During the back half of each M1 cycle it puts a refresh address on the address bus, made of the interrupt-vector byte and the refresh register, and pulls the refresh strobe low. At the end of each M1 cycle it advances the refresh register.

The decoder supplies four hints during the last T-state of every fetch cycle: the byte just read was a prefix, a displacement byte comes next (the indexed bit-operation form), the instruction is complete, or a block instruction repeats. From these hints the block chooses the next cycle. The four-byte indexed bit-operation form runs a fixed six-cycle pattern, and within it the displacement is an ordinary read. The parameter `FINAL_M1` selects whether the last opcode byte of that form is an M1 or a plain read.

Top module: `refresh_seq`

## Requirements
- R1: While `rst_n` is low, `r_q` is 0 and the block sits in T-state 1 (`t_st`=1) of an M1 cycle (`mc_type`=0), with `m1_n` low and `rfsh_n` high.
- R2: In an M1 cycle, `m1_n` is low in T1 and T2 and `rfsh_n` is low in T3 and T4. While `rfsh_n` is low, `addr` equals {`ivec`, `r_q`}. At every other time `addr` equals `fetch_addr`.
- R3: At the clock edge that ends an M1 cycle, bits 6:0 of `r_q` increment by one modulo 128 and bit 7 keeps its value (0xFF becomes 0x80, 0x7F becomes 0x00).
- R4: `mc_type` encodes 0 as M1, 1 as memory read and 2 as memory write. An operand byte is read with a 3-T read cycle, and R does not change outside M1 cycles.
- R5: When `hint_prefix` is high at the end of a fetch, the next byte is fetched with a 4-T M1, so an instruction with one prefix advances R by two.
- R6: The indexed bit-operation form (prefix, then a byte with `hint_disp`) runs cycles of 4, 4, 3, 5, 4 and 3 T-states, 23 in total, of types M1, M1, read, final, read, write. With `FINAL_M1`=0 the final cycle is a read and R advances by two.
- R7: With `FINAL_M1`=1 the 5-T final opcode cycle is an M1 with refresh in T3 and T4, and R advances by three over the form.
- R8: When `hint_rep` is high, the next fetch is a new M1, so a repeating block instruction advances R on every repetition.
- R9: A pulse on `r_wr` loads all eight bits of `r_wdata` into R. It takes priority over an increment at the same edge, and the following M1 increments only bits 6:0.
- R10: Hints are taken only at the end of a fetch cycle (M1 or operand read), with the priority done/repeat, then displacement, then prefix. During the displacement, final and execute cycles they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hint_prefix | input | 1 | Fetched byte was a prefix |
| hint_disp | input | 1 | Displacement byte of the indexed bit-operation form follows |
| hint_done | input | 1 | Instruction complete |
| hint_rep | input | 1 | Block instruction repeats |
| r_wr | input | 1 | Load R from r_wdata |
| r_wdata | input | 8 | Value loaded into R |
| ivec | input | 8 | Interrupt-vector byte for the refresh address |
| fetch_addr | input | 16 | Address shown outside refresh |
| addr | output | 16 | Address bus |
| m1_n | output | 1 | Active-low opcode-fetch strobe |
| rfsh_n | output | 1 | Active-low refresh strobe |
| mc_type | output | 2 | Current machine-cycle type |
| t_st | output | 3 | Current T-state, from 1 |
| cyc_last | output | 1 | Last T-state of the current machine cycle |
| r_q | output | 8 | Refresh register |

## Verification
The bench builds two copies side by side from the same stimulus: one with `FINAL_M1`=0 and one with `FINAL_M1`=1. The cycle lengths are identical in both, so a single sequence of hints drives both. Only the type of the final opcode cycle, its refresh strobe and the R count differ between the copies, which places the two- and three-increment outcomes of the indexed form next to each other. Ignored hints, hint priority, wrap of the low seven bits and a load at the same edge as an increment are exercised on both copies.

// File: rtl/refresh_seq.sv
module refresh_seq #(
  parameter bit FINAL_M1 = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hint_prefix,
  input  logic        hint_disp,
  input  logic        hint_done,
  input  logic        hint_rep,
  input  logic        r_wr,
  input  logic [7:0]  r_wdata,
  input  logic [7:0]  ivec,
  input  logic [15:0] fetch_addr,
  output logic [15:0] addr,
  output logic        m1_n,
  output logic        rfsh_n,
  output logic [1:0]  mc_type,
  output logic [2:0]  t_st,
  output logic        cyc_last,
  output logic [7:0]  r_q
);

  localparam logic [1:0] MC_M1 = 2'd0;
  localparam logic [1:0] MC_RD = 2'd1;
  localparam logic [1:0] MC_WR = 2'd2;

  typedef enum logic [2:0] {P_OPC, P_OPND, P_DISP, P_FIN, P_EXR, P_EXW} phase_t;

  phase_t     ph, ph_nxt;
  logic [2:0] t, len;
  logic [1:0] ty;
  logic [7:0] r;
  logic       is_m1;

  always_comb begin
    case (ph)
      P_OPC:   begin len = 3'd4; ty = MC_M1; end
      P_OPND:  begin len = 3'd3; ty = MC_RD; end
      P_DISP:  begin len = 3'd3; ty = MC_RD; end
      P_FIN:   begin len = 3'd5; ty = FINAL_M1 ? MC_M1 : MC_RD; end
      P_EXR:   begin len = 3'd4; ty = MC_RD; end
      P_EXW:   begin len = 3'd3; ty = MC_WR; end
      default: begin len = 3'd4; ty = MC_M1; end
    endcase
  end

  always_comb begin
    case (ph)
      P_OPC, P_OPND: begin
        if (hint_done || hint_rep) ph_nxt = P_OPC;
        else if (hint_disp)        ph_nxt = P_DISP;
        else if (hint_prefix)      ph_nxt = P_OPC;
        else                       ph_nxt = P_OPND;
      end
      P_DISP:  ph_nxt = P_FIN;
      P_FIN:   ph_nxt = P_EXR;
      P_EXR:   ph_nxt = P_EXW;
      default: ph_nxt = P_OPC;
    endcase
  end

  assign is_m1    = (ty == MC_M1);
  assign cyc_last = (t == len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= P_OPC;
      t  <= 3'd1;
      r  <= 8'd0;
    end else begin
      if (cyc_last) begin
        ph <= ph_nxt;
        t  <= 3'd1;
      end else begin
        t  <= t + 3'd1;
      end
      if (r_wr)                  r <= r_wdata;
      else if (cyc_last && is_m1) r <= {r[7], r[6:0] + 7'd1};
    end
  end

  assign m1_n    = ~(is_m1 && (t <= 3'd2));
  assign rfsh_n  = ~(is_m1 && ((t == 3'd3) || (t == 3'd4)));
  assign addr    = rfsh_n ? fetch_addr : {ivec, r};
  assign mc_type = ty;
  assign t_st    = t;
  assign r_q     = r;

endmodule

// File: rtl/refresh_seq_chk.sv
module refresh_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        r_wr,
  input logic [7:0]  r_wdata,
  input logic [7:0]  ivec,
  input logic [15:0] addr,
  input logic        m1_n,
  input logic        rfsh_n,
  input logic [1:0]  mc_type,
  input logic [2:0]  t_st,
  input logic        cyc_last,
  input logic [7:0]  r_q
);

  AST_BIT7_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_last && mc_type == 2'd0 && !r_wr) |=> (r_q == {$past(r_q[7]), $past(r_q[6:0]) + 7'd1})); // R3

  AST_NO_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_wr && !(cyc_last && mc_type == 2'd0)) |=> $stable(r_q)); // R4

  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    r_wr |=> (r_q == $past(r_wdata))); // R9

  AST_RFSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> (addr == {ivec, r_q})); // R2

  AST_RFSH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> (mc_type == 2'd0 && (t_st == 3'd3 || t_st == 3'd4))); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !m1_n |-> rfsh_n); // R2

  AST_T_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (t_st != 3'd0) && (t_st <= 3'd5)); // R6

  AST_T_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_last |=> (t_st == 3'd1)); // R6

endmodule

bind refresh_seq refresh_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .r_wr(r_wr), .r_wdata(r_wdata), .ivec(ivec),
  .addr(addr), .m1_n(m1_n), .rfsh_n(rfsh_n), .mc_type(mc_type),
  .t_st(t_st), .cyc_last(cyc_last), .r_q(r_q)
);

// File: tb/test_refresh_seq.sv
module test_refresh_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hint_prefix = 1'b0, hint_disp = 1'b0, hint_done = 1'b0, hint_rep = 1'b0;
  logic r_wr = 1'b0;
  logic [7:0] r_wdata = 8'h00;
  logic [7:0] ivec = 8'h3C;
  logic [15:0] fetch_addr = 16'hA5F0;

  logic [15:0] addr0, addr1;
  logic m1n0, m1n1, rf0, rf1, last0, last1;
  logic [1:0] ty0, ty1;
  logic [2:0] t0, t1;
  logic [7:0] r0, r1;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  refresh_seq #(.FINAL_M1(1'b0)) i_refresh_seq (
    .clk(clk), .rst_n(rst_n), .hint_prefix(hint_prefix), .hint_disp(hint_disp),
    .hint_done(hint_done), .hint_rep(hint_rep), .r_wr(r_wr), .r_wdata(r_wdata),
    .ivec(ivec), .fetch_addr(fetch_addr), .addr(addr0), .m1_n(m1n0), .rfsh_n(rf0),
    .mc_type(ty0), .t_st(t0), .cyc_last(last0), .r_q(r0));

  refresh_seq #(.FINAL_M1(1'b1)) i_refresh_seq_m1 (
    .clk(clk), .rst_n(rst_n), .hint_prefix(hint_prefix), .hint_disp(hint_disp),
    .hint_done(hint_done), .hint_rep(hint_rep), .r_wr(r_wr), .r_wdata(r_wdata),
    .ivec(ivec), .fetch_addr(fetch_addr), .addr(addr1), .m1_n(m1n1), .rfsh_n(rf1),
    .mc_type(ty1), .t_st(t1), .cyc_last(last1), .r_q(r1));

  // {prefix, disp, done, rep, type0, type1, len, r0_after, r1_after}
  localparam int NV = 20;
  localparam logic [26:0] VEC [NV] = '{
    {4'b0010, 2'd0, 2'd0, 3'd4, 8'h01, 8'h01},
    {4'b0000, 2'd0, 2'd0, 3'd4, 8'h02, 8'h02},
    {4'b0010, 2'd1, 2'd1, 3'd3, 8'h02, 8'h02},
    {4'b1000, 2'd0, 2'd0, 3'd4, 8'h03, 8'h03},
    {4'b0001, 2'd0, 2'd0, 3'd4, 8'h04, 8'h04},
    {4'b1000, 2'd0, 2'd0, 3'd4, 8'h05, 8'h05},
    {4'b0010, 2'd0, 2'd0, 3'd4, 8'h06, 8'h06},
    {4'b1000, 2'd0, 2'd0, 3'd4, 8'h07, 8'h07},
    {4'b0100, 2'd0, 2'd0, 3'd4, 8'h08, 8'h08},
    {4'b1000, 2'd1, 2'd1, 3'd3, 8'h08, 8'h08},
    {4'b1000, 2'd1, 2'd0, 3'd5, 8'h08, 8'h09},
    {4'b0010, 2'd1, 2'd1, 3'd4, 8'h08, 8'h09},
    {4'b0001, 2'd2, 2'd2, 3'd3, 8'h08, 8'h09},
    {4'b1110, 2'd0, 2'd0, 3'd4, 8'h09, 8'h0A},
    {4'b1100, 2'd0, 2'd0, 3'd4, 8'h0A, 8'h0B},
    {4'b0000, 2'd1, 2'd1, 3'd3, 8'h0A, 8'h0B},
    {4'b0000, 2'd1, 2'd0, 3'd5, 8'h0A, 8'h0C},
    {4'b0000, 2'd1, 2'd1, 3'd4, 8'h0A, 8'h0C},
    {4'b0000, 2'd2, 2'd2, 3'd3, 8'h0A, 8'h0C},
    {4'b0010, 2'd0, 2'd0, 3'd4, 8'h0B, 8'h0D}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit strobes_ok(input logic [1:0] ty, input int k, input logic m1n,
                                    input logic rf, input logic [15:0] a, input logic [7:0] pr);
    bit exp_m1n, exp_rf;
    exp_m1n = !(ty == 2'd0 && k <= 2);
    exp_rf  = !(ty == 2'd0 && (k == 3 || k == 4));
    if (m1n !== exp_m1n || rf !== exp_rf) return 1'b0;
    if (!exp_rf) return (a === {ivec, pr});
    return (a === fetch_addr);
  endfunction

  // Walk one machine cycle from its T1, present hints on its last T-state.
  task automatic walk(input logic [3:0] h, input logic [1:0] e0, input logic [1:0] e1,
                      input logic [7:0] p0, input logic [7:0] p1, output int len);
    int k;
    bit bad;
    k = 1;
    bad = 1'b0;
    check(ty0 === e0, "R4/R6 cycle type (FINAL_M1=0)", ty0, e0);
    check(ty1 === e1, "R7 cycle type (FINAL_M1=1)", ty1, e1);
    while (1) begin
      if (!strobes_ok(e0, k, m1n0, rf0, addr0, p0)) bad = 1'b1;
      if (!strobes_ok(e1, k, m1n1, rf1, addr1, p1)) bad = 1'b1;
      if (last0 || k > 8) break;
      @(negedge clk);
      k++;
    end
    check(!bad, "R2 strobes and address", bad, 0);
    {hint_prefix, hint_disp, hint_done, hint_rep} = h;
    @(negedge clk);
    {hint_prefix, hint_disp, hint_done, hint_rep} = 4'b0000;
    len = k;
  endtask

  task automatic run_to_end_done;
    while (!last0) @(negedge clk);
    hint_done = 1'b1;
    @(negedge clk);
    hint_done = 1'b0;
  endtask

  initial begin
    int len;
    logic [7:0] p0, p1;
    repeat (3) @(negedge clk);
    check(r0 === 8'h00 && r1 === 8'h00, "R1 reset R", r0, 0);
    check(t0 === 3'd1 && ty0 === 2'd0, "R1 reset T1 of M1", {ty0, t0}, 1);
    check(m1n0 === 1'b0 && rf0 === 1'b1, "R1 reset strobes", {m1n0, rf0}, 1);
    rst_n = 1'b1;

    p0 = 8'h00;
    p1 = 8'h00;
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      walk(v[26:23], v[22:21], v[20:19], p0, p1, len);
      check(len == int'(v[18:16]), "R6/R10 cycle length", len, v[18:16]);
      check(r0 === v[15:8], "R3/R5/R8 R count (FINAL_M1=0)", r0, v[15:8]);
      check(r1 === v[7:0], "R7 R count (FINAL_M1=1)", r1, v[7:0]);
      p0 = v[15:8];
      p1 = v[7:0];
    end

    // R9: load all eight bits, then bit 7 kept on increment (R3 wrap)
    r_wr = 1'b1; r_wdata = 8'hFF;
    @(negedge clk);
    r_wr = 1'b0;
    check(r0 === 8'hFF && r1 === 8'hFF, "R9 load all bits", r0, 8'hFF);
    run_to_end_done();
    check(r0 === 8'h80 && r1 === 8'h80, "R3 bit7 kept, low bits wrap", r0, 8'h80);

    r_wr = 1'b1; r_wdata = 8'h7F;
    @(negedge clk);
    r_wr = 1'b0;
    run_to_end_done();
    check(r0 === 8'h00 && r1 === 8'h00, "R3 0x7F wraps to 0x00", r0, 8'h00);

    // R9: load at the same edge as an increment wins
    while (!last0) @(negedge clk);
    r_wr = 1'b1; r_wdata = 8'h55; hint_done = 1'b1;
    @(negedge clk);
    r_wr = 1'b0; hint_done = 1'b0;
    check(r0 === 8'h55 && r1 === 8'h55, "R9 load wins over increment", r0, 8'h55);
    run_to_end_done();
    check(r0 === 8'h56 && r1 === 8'h56, "R9 next M1 increments", r0, 8'h56);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule